// File: doc/BRIEF.md
# Sloppy 128-bit Modular Multiplier

This block multiplies two 128-bit operands and brings the 256-bit product back to 128 bits modulo the redundant modulus 2^128 − 3. Because 2^128 is congruent to 3 for that modulus, a product split as high·2^128 + low can be replaced by low + 3·high without changing its residue. The block applies this fold twice and stops there. It does no final compare-and-subtract, so a result can sit slightly above 2^128. That rare case is reported on a separate overflow output rather than corrected.

The product is built with one 16×16→32-bit multiply-accumulate unit that runs over many cycles. The operands are treated as eight 16-bit limbs each. Partial products are summed column by column: each column sum goes into a small guarded accumulator, which emits one 16-bit product limb and carries the rest into the next column. A controller steps through the states IDLE, MUL, FOLD1, FOLD2 and DONE, with these transitions:

- IDLE→MUL when a start is accepted.
- MUL→MUL for each of the 64 limb products.
- MUL→FOLD1 after the last product.
- FOLD1→FOLD2, then FOLD2→DONE, one cycle each.
- DONE→MUL when a new start is accepted; DONE→DONE otherwise.

Top module: `sloppy_mulmod`

## Requirements
- R1: The value V = ovf_o·2^128 + result_o is congruent to op_a_i·op_b_i modulo 2^128 − 3.
- R2: When ovf_o is 1, result_o is at most 5, so V never exceeds 2^128 + 5.
- R3: V equals exactly the two-fold value. Let P = a·b. Then Y = P[127:0] + 3·P[255:128], and V = Y[127:0] + 3·Y[129:128], with no further correction. The all-ones operand pair therefore gives ovf_o = 1 and result_o = 1.
- R4: A start is accepted when start_i is 1 and busy_o is 0. After the accepting clock edge, busy_o stays 1 and done_o stays 0 for exactly 66 rising edges; done_o rises on the 66th. busy_o and done_o are never both 1.
- R5: A start_i pulse while busy_o is 1 is ignored. The operands in flight are kept, the latency does not change, and the result belongs to the first pair.
- R6: While done_o stays 1, result_o and ovf_o hold their values.
- R7: During reset and at its release, busy_o, done_o, result_o and ovf_o are all 0.
- R8: A start accepted from the DONE state restarts the block. After that edge busy_o is 1 and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply of the present operands |
| op_a_i | input | 128 | First operand, captured at the accepting edge |
| op_b_i | input | 128 | Second operand, captured at the accepting edge |
| busy_o | output | 1 | Multiply or fold in progress |
| done_o | output | 1 | Result valid, held until the next accepted start |
| result_o | output | 128 | Low 128 bits of the second fold |
| ovf_o | output | 1 | Bit 128 of the second fold |

## Verification
Zero and unit operands show whether the column scheduling and carry chaining leave a plain product untouched. Products that stay below 2^128, such as 2^127·2^127 folded once, separate the first fold from the second. The all-ones pair drives both folds to their limits and must raise the overflow flag with a result of 1. A modulus-valued operand must yield a result congruent to zero. Alternating bit patterns and random operands exercise carries that cross every limb boundary. Each of these results is compared both with the exact two-fold value and, modulo 2^128 − 3, with the true product.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_FOLD1,
        ST_FOLD2,
        ST_DONE
    } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int N_LIMBS = 8
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  start_i,
    output logic                                  accept_o,
    output logic                                  mac_en_o,
    output logic                                  col_end_o,
    output logic                                  last_o,
    output logic                                  fold1_en_o,
    output logic                                  fold2_en_o,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic [$clog2(2*N_LIMBS-1)-1:0]        col_o,
    output logic [$clog2(N_LIMBS)-1:0]            ia_o,
    output logic [$clog2(N_LIMBS)-1:0]            ib_o
);

    localparam int COL_W    = $clog2(2*N_LIMBS-1);
    localparam int IDX_W    = $clog2(N_LIMBS);
    localparam int LAST_COL = 2*N_LIMBS - 2;

    smul_state_e state_q, state_d;
    logic [COL_W-1:0] col_q;
    logic [IDX_W-1:0] i_q;
    logic             col_end_c;
    logic             last_c;
    logic [IDX_W-1:0] next_lo_c;
    logic [IDX_W-1:0] ib_c;

    // Column schedule: column k pairs limb i of A with limb k-i of B.
    always_comb begin
        int k_v;
        int hi_v;
        int lo_v;
        k_v       = int'(col_q);
        hi_v      = (k_v < N_LIMBS) ? k_v : N_LIMBS - 1;
        lo_v      = (k_v + 1 >= N_LIMBS) ? (k_v + 2 - N_LIMBS) : 0;
        col_end_c = (int'(i_q) == hi_v);
        last_c    = (k_v == LAST_COL);
        next_lo_c = IDX_W'(lo_v);
        ib_c      = IDX_W'(k_v - int'(i_q));
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_MUL;
            ST_MUL:   if (col_end_c && last_c) state_d = ST_FOLD1;
            ST_FOLD1: state_d = ST_FOLD2;
            ST_FOLD2: state_d = ST_DONE;
            ST_DONE:  if (start_i) state_d = ST_MUL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o     = (state_q == ST_MUL) || (state_q == ST_FOLD1) || (state_q == ST_FOLD2);
        done_o     = (state_q == ST_DONE);
        mac_en_o   = (state_q == ST_MUL);
        fold1_en_o = (state_q == ST_FOLD1);
        fold2_en_o = (state_q == ST_FOLD2);
        accept_o   = start_i && !busy_o;
        col_end_o  = col_end_c;
        last_o     = last_c;
        col_o      = col_q;
        ia_o       = i_q;
        ib_o       = ib_c;
    end

    // Limb index counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            col_q <= '0;
            i_q   <= '0;
        end else if (accept_o) begin
            col_q <= '0;
            i_q   <= '0;
        end else if (mac_en_o) begin
            if (col_end_c) begin
                if (!last_c) begin
                    col_q <= col_q + COL_W'(1);
                    i_q   <= next_lo_c;
                end
            end else begin
                i_q <= i_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/smul_mac.sv
module smul_mac #(
    parameter int LIMB_W  = 16,
    parameter int N_LIMBS = 8
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 clear_i,
    input  logic                                 en_i,
    input  logic                                 col_end_i,
    input  logic                                 last_i,
    input  logic [$clog2(2*N_LIMBS-1)-1:0]       col_i,
    input  logic [LIMB_W-1:0]                    a_limb_i,
    input  logic [LIMB_W-1:0]                    b_limb_i,
    output logic [2*N_LIMBS*LIMB_W-1:0]          prod_o
);

    localparam int PROD_W = 2 * N_LIMBS * LIMB_W;
    localparam int PP_W   = 2 * LIMB_W;
    localparam int ACC_W  = PP_W + $clog2(N_LIMBS) + 1;
    localparam int TOP_LIMB = 2 * N_LIMBS - 1;

    logic [ACC_W-1:0]  acc_q;
    logic [PROD_W-1:0] prod_q;
    logic [PP_W-1:0]   pp_c;
    logic [ACC_W-1:0]  sum_c;

    always_comb begin
        pp_c  = PP_W'(a_limb_i) * PP_W'(b_limb_i);
        sum_c = acc_q + ACC_W'(pp_c);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            prod_q <= '0;
        end else if (clear_i) begin
            acc_q  <= '0;
            prod_q <= '0;
        end else if (en_i) begin
            if (col_end_i) begin
                prod_q[int'(col_i)*LIMB_W +: LIMB_W] <= sum_c[LIMB_W-1:0];
                acc_q <= sum_c >> LIMB_W;
                if (last_i) begin
                    prod_q[TOP_LIMB*LIMB_W +: LIMB_W] <= sum_c[2*LIMB_W-1:LIMB_W];
                end
            end else begin
                acc_q <= sum_c;
            end
        end
    end

    assign prod_o = prod_q;

endmodule

// File: rtl/smul_fold.sv
module smul_fold #(
    parameter int IN_W  = 256,
    parameter int LO_W  = 128,
    parameter int C_VAL = 3,
    parameter int OUT_W = 130
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] y_o
);

    always_comb begin
        y_o = OUT_W'(x_i[LO_W-1:0]) + OUT_W'(x_i[IN_W-1:LO_W]) * OUT_W'(C_VAL);
    end

endmodule

// File: rtl/sloppy_mulmod.sv
module sloppy_mulmod #(
    parameter int LIMB_W  = 16,
    parameter int N_LIMBS = 8,
    parameter int FOLD_C  = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        start_i,
    input  logic [LIMB_W*N_LIMBS-1:0]   op_a_i,
    input  logic [LIMB_W*N_LIMBS-1:0]   op_b_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [LIMB_W*N_LIMBS-1:0]   result_o,
    output logic                        ovf_o
);

    localparam int OP_W    = LIMB_W * N_LIMBS;
    localparam int PROD_W  = 2 * OP_W;
    localparam int C_W     = $clog2(FOLD_C + 1);
    localparam int Y_W     = OP_W + C_W;
    localparam int Z_W     = OP_W + 1;
    localparam int COL_W   = $clog2(2*N_LIMBS-1);
    localparam int IDX_W   = $clog2(N_LIMBS);
    localparam int OVF_LIM = FOLD_C*FOLD_C - FOLD_C - 1;

    logic              accept;
    logic              mac_en;
    logic              col_end;
    logic              last;
    logic              fold1_en;
    logic              fold2_en;
    logic [COL_W-1:0]  col;
    logic [IDX_W-1:0]  ia;
    logic [IDX_W-1:0]  ib;
    logic [OP_W-1:0]   op_a_q;
    logic [OP_W-1:0]   op_b_q;
    logic [LIMB_W-1:0] a_limb;
    logic [LIMB_W-1:0] b_limb;
    logic [PROD_W-1:0] prod;
    logic [Y_W-1:0]    y_d;
    logic [Y_W-1:0]    y_q;
    logic [Z_W-1:0]    z_d;
    logic [OP_W-1:0]   res_q;
    logic              ovf_q;

    smul_ctrl #(.N_LIMBS(N_LIMBS)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .accept_o   (accept),
        .mac_en_o   (mac_en),
        .col_end_o  (col_end),
        .last_o     (last),
        .fold1_en_o (fold1_en),
        .fold2_en_o (fold2_en),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .col_o      (col),
        .ia_o       (ia),
        .ib_o       (ib)
    );

    // Operand capture on an accepted start only
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (accept) begin
            op_a_q <= op_a_i;
            op_b_q <= op_b_i;
        end
    end

    always_comb begin
        a_limb = op_a_q[int'(ia)*LIMB_W +: LIMB_W];
        b_limb = op_b_q[int'(ib)*LIMB_W +: LIMB_W];
    end

    smul_mac #(.LIMB_W(LIMB_W), .N_LIMBS(N_LIMBS)) u_mac (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (accept),
        .en_i      (mac_en),
        .col_end_i (col_end),
        .last_i    (last),
        .col_i     (col),
        .a_limb_i  (a_limb),
        .b_limb_i  (b_limb),
        .prod_o    (prod)
    );

    smul_fold #(.IN_W(PROD_W), .LO_W(OP_W), .C_VAL(FOLD_C), .OUT_W(Y_W)) u_fold_hi (
        .x_i (prod),
        .y_o (y_d)
    );

    smul_fold #(.IN_W(Y_W), .LO_W(OP_W), .C_VAL(FOLD_C), .OUT_W(Z_W)) u_fold_lo (
        .x_i (y_q),
        .y_o (z_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            y_q   <= '0;
            res_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (fold1_en) y_q <= y_d;
            if (fold2_en) begin
                res_q <= z_d[OP_W-1:0];
                ovf_q <= z_d[OP_W];
            end
        end
    end

    assign result_o = res_q;
    assign ovf_o    = ovf_q;

endmodule

// File: rtl/sloppy_mulmod_chk.sv
module sloppy_mulmod_chk #(
    parameter int OP_W    = 128,
    parameter int OVF_LIM = 5
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [OP_W-1:0] result_o,
    input logic            ovf_o,
    input logic [OP_W-1:0] op_a_q,
    input logic [OP_W-1:0] op_b_q
);

    // R2: an overflowing result is only a few units above 2^OP_W
    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (result_o <= OP_W'(OVF_LIM)));

    // R4: busy and done are exclusive
    p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    // R4: busy only ends by entering done
    p_busy_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));

    // R5: captured operands do not move during a run
    p_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(op_a_q) && $stable(op_b_q)));

    // R6: result held while done stays high
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(done_o)) |-> ($stable(result_o) && $stable(ovf_o)));

    // R8: an accepted start enters the busy phase
    p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !done_o));

endmodule

bind sloppy_mulmod sloppy_mulmod_chk #(.OP_W(OP_W), .OVF_LIM(OVF_LIM)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .op_a_q   (op_a_q),
    .op_b_q   (op_b_q)
);

// File: tb/sloppy_mulmod_bench.sv
`timescale 1ns/1ps
module sloppy_mulmod_bench;

    localparam int OP_W = 128;
    localparam int LAT  = 66;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [OP_W-1:0] op_a = '0;
    logic [OP_W-1:0] op_b = '0;
    logic            busy;
    logic            done;
    logic [OP_W-1:0] result;
    logic            ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [384:0] exp_q[$];

    always #5 clk = ~clk;

    sloppy_mulmod u_sloppy_mulmod (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .busy_o   (busy),
        .done_o   (done),
        .result_o (result),
        .ovf_o    (ovf)
    );

    function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b);
        logic [255:0] x;
        logic [129:0] y;
        logic [128:0] z;
        x = {128'd0, a} * {128'd0, b};
        y = {2'b00, x[127:0]} + 130'(x[255:128]) * 130'd3;
        z = {1'b0, y[127:0]} + 129'(y[129:128]) * 129'd3;
        return z;
    endfunction

    task automatic check(input bit ok, input string req, input logic [257:0] act, input logic [257:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    initial begin
        logic done_d;
        logic [384:0] item;
        logic [127:0] a, b;
        logic [128:0] z, full;
        logic [257:0] pm, m_exp, m_act;
        done_d = 1'b0;
        pm = (258'd1 << 128) - 258'd3;
        forever begin
            @(posedge clk); #1;
            if (rst_n && done && !done_d) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected result", 258'(result), 258'd0);
                end else begin
                    item = exp_q.pop_front();
                    a = item[384:257];
                    b = item[256:129];
                    z = item[128:0];
                    full = {ovf, result};
                    check(full == z, "R3 two-fold value", 258'(full), 258'(z));
                    m_exp = (258'(a) * 258'(b)) % pm;
                    m_act = 258'(full) % pm;
                    check(m_act == m_exp, "R1 congruence", m_act, m_exp);
                    check(!ovf || (result <= 128'd5), "R2 overflow bound", 258'(full), 258'd5);
                end
            end
            done_d = done;
        end
    end

    // Driver: one multiply, with latency and restart checks (R4, R8)
    task automatic run_op(input logic [127:0] a, input logic [127:0] b);
        int cnt;
        @(negedge clk);
        op_a = a;
        op_b = b;
        start = 1'b1;
        exp_q.push_back({a, b, model(a, b)});
        @(posedge clk); #1;
        start = 1'b0;
        check(busy && !done, "R8 accept", {256'd0, busy, done}, 258'd2);
        cnt = 0;
        while (!done) begin
            @(posedge clk); #1;
            cnt++;
        end
        check(cnt == LAT, "R4 latency", 258'(cnt), 258'(LAT));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        logic [127:0] ones;
        logic [127:0] hold_r;
        logic [127:0] pa;
        logic hold_o;
        int cnt;
        ones = '1;

        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!busy && !done && result == '0 && !ovf, "R7 reset state",
              {result, busy, done}, 258'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(!busy && !done && result == '0 && !ovf, "R7 after release",
              {result, busy, done}, 258'd0);

        run_op('0, rnd128());
        run_op(128'd1, rnd128());
        run_op(128'd1 << 127, 128'd1 << 127);
        // R3 boundary: all-ones pair overflows to 2^128 + 1
        run_op(ones, ones);
        check(ovf == 1'b1 && result == 128'd1, "R3 all-ones overflow",
              {ovf, result}, (258'd1 << 128) + 258'd1);
        run_op(ones - 128'd2, rnd128());
        run_op({8{16'hAAAA}}, {8{16'h5555}});
        run_op(ones, 128'd1);

        // R6: result held while done stays high
        hold_r = result;
        hold_o = ovf;
        repeat (5) @(posedge clk);
        #1;
        check(done && result == hold_r && ovf == hold_o, "R6 hold",
              {ovf, result}, {hold_o, hold_r});

        for (int k = 0; k < 6; k++) run_op(rnd128(), rnd128());

        // R5: start pulse while busy is ignored
        pa = rnd128();
        @(negedge clk);
        op_a = pa;
        op_b = ones;
        start = 1'b1;
        exp_q.push_back({pa, ones, model(pa, ones)});
        @(posedge clk); #1;
        start = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        op_a = rnd128();
        op_b = 128'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 11;
        while (!done) begin
            @(posedge clk); #1;
            cnt++;
        end
        check(cnt == LAT, "R5 latency kept", 258'(cnt), 258'(LAT));
        check({ovf, result} == model(pa, ones), "R5 first operands used",
              258'({ovf, result}), 258'(model(pa, ones)));

        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R4 all results seen", 258'(exp_q.size()), 258'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule